// File: doc/BRIEF.md
# Interrupt Source Coalescing State Machine

This block keeps a two-bit state for each interrupt source in a bank. The upper bit (pending) says that an event for the source has been sent out and is waiting for end-of-interrupt. The lower bit (queued) records that a further trigger arrived while the source was pending. A hardware trigger on an idle source issues one notification and sets the pending bit. Triggers that arrive while the source is pending only set the queued bit. When software ends the interrupt, a set queued bit causes a fresh notification. As a result, a source is never outstanding more than once downstream.

Software reaches each source through its own 4 KiB page of a load/store window. Loads at fixed offsets in the page read the state, force it to a chosen value, or perform end-of-interrupt. Every such load returns the state the source held before the access, as one atomic step. A store to a dedicated offset can also perform end-of-interrupt. Notifications leave through a valid/ready port that carries the index of the source.

Top module: `irq_pq_bank`

## Requirements
- R1: After reset every source is in state 00 (idle), notify_valid_o is low and resp_valid_o is low.
- R2: A load at page offset 0x800 returns the source state in resp_data_o bits [1:0] (bit 1 pending, bit 0 queued, upper bits zero) and leaves the state unchanged.
- R3: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11, return the prior state, and raise no notification.
- R4: A trigger on a source in state 00 moves it to 10 and raises a notification. A trigger in state 10 moves it to 11. A trigger in state 11 leaves it at 11. Neither of the last two raises a notification.
- R5: A source in state 01 is masked. Triggers leave it at 01 and raise no notification.
- R6: A load at offset 0x000 performs end-of-interrupt and returns the prior state. State 11 becomes 10 with a new notification. State 10 becomes 00. States 00 and 01 are unchanged.
- R7: When STORE_EOI_EN is 1, a store at offset 0x400 performs the same end-of-interrupt as R6. All other stores have no effect. Stores never produce a response.
- R8: The source is selected by req_addr_i[ADDR_W-1:PAGE_BITS]. A load to a page index of NUM_SRC or more, or to an offset other than those in R2, R3 and R6, returns all ones and changes no state.
- R9: When a trigger and a window access hit the same source in one cycle, the access is applied first and the trigger is then evaluated on its result. The response carries the state from before both.
- R10: notify_valid_o rises in the cycle after a notification event. notify_src_o gives the lowest-numbered source with a notification not yet accepted. That source stays pending until a cycle with notify_valid_o and notify_ready_i both high. Further events for that source are merged into the one outstanding notification.
- R11: Every load request gives resp_valid_o high in exactly the next cycle, with resp_data_o valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_SRC | One trigger bit per source, sampled each cycle |
| req_valid_i | input | 1 | Window access request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address in the window (page index above PAGE_BITS) |
| resp_valid_o | output | 1 | Load response valid |
| resp_data_o | output | 64 | Prior state, or all ones for an unmapped load |
| notify_valid_o | output | 1 | A notification is offered |
| notify_src_o | output | $clog2(NUM_SRC) | Index of the notified source |
| notify_ready_i | input | 1 | Consumer accepts the notification |

## Verification
A wrong stored state shows up at the ports in one of two ways. The next read-back load of that source returns the bad value one cycle later. Otherwise, the next trigger or end-of-interrupt produces a notification that should not exist, or misses one that should, and this appears on notify_valid_o the cycle after. The bench runs a behavioural model of every source and of the notification bitmap alongside the design. It compares the response and the notification port on every cycle, so a divergence is reported in the first cycle it becomes visible. The same-cycle collisions of a trigger with a forcing load or an end-of-interrupt are driven on purpose, because that is where the order of operations is visible.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

   typedef enum logic [1:0] {
      PQ_OP_NONE = 2'd0,
      PQ_OP_GET  = 2'd1,
      PQ_OP_EOI  = 2'd2,
      PQ_OP_SET  = 2'd3
   } pq_op_e;

   typedef struct packed {
      pq_op_e     op;
      logic [1:0] val;
   } pq_cmd_t;

   localparam logic [1:0] PQ_IDLE   = 2'b00;
   localparam logic [1:0] PQ_MASKED = 2'b01;
   localparam logic [1:0] PQ_PEND   = 2'b10;
   localparam logic [1:0] PQ_PENDQ  = 2'b11;

   localparam logic [11:0] OFF_LOAD_EOI  = 12'h000;
   localparam logic [11:0] OFF_STORE_EOI = 12'h400;
   localparam logic [11:0] OFF_GET       = 12'h800;
   localparam logic [11:0] OFF_SET_00    = 12'hC00;
   localparam logic [11:0] OFF_SET_01    = 12'hD00;
   localparam logic [11:0] OFF_SET_10    = 12'hE00;
   localparam logic [11:0] OFF_SET_11    = 12'hF00;

endpackage

// File: rtl/irq_pq_decode.sv
module irq_pq_decode
   import irq_pq_pkg::*;
#(
   parameter int NUM_SRC      = 8,
   parameter int ADDR_W       = 16,
   parameter int PAGE_BITS    = 12,
   parameter bit STORE_EOI_EN = 1'b1,
   localparam int SRC_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int PG_W        = ADDR_W - PAGE_BITS
)(
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output pq_cmd_t           cmd_o,
   output logic [NUM_SRC-1:0] sel_o,
   output logic [SRC_W-1:0]  src_o,
   output logic              load_hit_o
);

   logic [PG_W-1:0]      page;
   logic [PAGE_BITS-1:0] off;
   logic                 page_ok;
   pq_op_e               load_op;
   pq_op_e               store_op;
   pq_cmd_t              cmd;

   assign page    = req_addr_i[ADDR_W-1:PAGE_BITS];
   assign off     = req_addr_i[PAGE_BITS-1:0];
   assign page_ok = (int'(page) < NUM_SRC);
   assign src_o   = page[SRC_W-1:0];

   always_comb begin
      load_op = PQ_OP_NONE;
      if (off == PAGE_BITS'(OFF_LOAD_EOI))     load_op = PQ_OP_EOI;
      else if (off == PAGE_BITS'(OFF_GET))     load_op = PQ_OP_GET;
      else if (off == PAGE_BITS'(OFF_SET_00) || off == PAGE_BITS'(OFF_SET_01) ||
               off == PAGE_BITS'(OFF_SET_10) || off == PAGE_BITS'(OFF_SET_11))
         load_op = PQ_OP_SET;
   end

   generate
      if (STORE_EOI_EN) begin : g_store_eoi
         assign store_op = (off == PAGE_BITS'(OFF_STORE_EOI)) ? PQ_OP_EOI : PQ_OP_NONE;
      end else begin : g_no_store_eoi
         assign store_op = PQ_OP_NONE;
      end
   endgenerate

   always_comb begin
      cmd.op  = PQ_OP_NONE;
      cmd.val = off[9:8];
      if (req_valid_i && page_ok) begin
         cmd.op = req_write_i ? store_op : load_op;
      end
   end

   assign cmd_o      = cmd;
   assign load_hit_o = req_valid_i && !req_write_i && (cmd.op != PQ_OP_NONE);

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
         assign sel_o[i] = (cmd.op != PQ_OP_NONE) && (int'(page) == i);
      end
   endgenerate

endmodule

// File: rtl/irq_pq_cell.sv
module irq_pq_cell
   import irq_pq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_i,
   input  pq_cmd_t    cmd_i,
   input  logic       trig_i,
   output logic [1:0] pq_o,
   output logic       evt_o
);

   logic [1:0] pq_q;
   logic [1:0] mid;
   logic [1:0] nxt;
   logic       acc_evt;
   logic       trg_evt;

   // Access first, then the trigger on the result.
   always_comb begin
      mid     = pq_q;
      acc_evt = 1'b0;
      if (sel_i) begin
         case (cmd_i.op)
            PQ_OP_SET: mid = cmd_i.val;
            PQ_OP_EOI: begin
               if (pq_q[1]) begin
                  if (pq_q[0]) begin
                     mid     = PQ_PEND;
                     acc_evt = 1'b1;
                  end else begin
                     mid = PQ_IDLE;
                  end
               end
            end
            default: mid = pq_q;
         endcase
      end
   end

   always_comb begin
      nxt     = mid;
      trg_evt = 1'b0;
      if (trig_i) begin
         case (mid)
            PQ_IDLE: begin
               nxt     = PQ_PEND;
               trg_evt = 1'b1;
            end
            PQ_PEND:  nxt = PQ_PENDQ;
            PQ_PENDQ: nxt = PQ_PENDQ;
            default:  nxt = PQ_MASKED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pq_q <= PQ_IDLE;
      else        pq_q <= nxt;
   end

   assign pq_o  = pq_q;
   assign evt_o = acc_evt | trg_evt;

   AST_TRIG_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_i && trig_i && pq_q == PQ_IDLE) |=> (pq_q == PQ_PEND)); // R4
   AST_MASKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_i && pq_q == PQ_MASKED) |=> (pq_q == PQ_MASKED)); // R5
   AST_EVENT_LEAVES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> pq_q[1]); // R6

endmodule

// File: rtl/irq_pq_notify_arb.sv
module irq_pq_notify_arb #(
   parameter int NUM_SRC = 8,
   localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               ready_i,
   output logic               valid_o,
   output logic [SRC_W-1:0]   src_o
);

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] grant_oh;
   logic [SRC_W-1:0]   grant_idx;
   logic               accept;

   always_comb begin
      grant_oh  = '0;
      grant_idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend_q[i]) begin
            grant_oh  = '0;
            grant_oh[i] = 1'b1;
            grant_idx = SRC_W'(i);
         end
      end
   end

   assign valid_o = |pend_q;
   assign src_o   = grant_idx;
   assign accept  = valid_o && ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~(accept ? grant_oh : '0)) | evt_i;
   end

   AST_NOTIFY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> valid_o); // R10
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_oh)); // R10

endmodule

// File: rtl/irq_pq_bank.sv
module irq_pq_bank
   import irq_pq_pkg::*;
#(
   parameter int NUM_SRC      = 8,
   parameter int ADDR_W       = 16,
   parameter int PAGE_BITS    = 12,
   parameter bit STORE_EOI_EN = 1'b1,
   localparam int SRC_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] trig_i,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   output logic               resp_valid_o,
   output logic [63:0]        resp_data_o,
   output logic               notify_valid_o,
   output logic [SRC_W-1:0]   notify_src_o,
   input  logic               notify_ready_i
);

   generate
      if (NUM_SRC < 1) begin : g_chk_num
         $error("NUM_SRC must be at least 1");
      end
      if (PAGE_BITS < 12) begin : g_chk_page
         $error("PAGE_BITS must cover the 12-bit control offsets");
      end
      if (ADDR_W - PAGE_BITS < SRC_W) begin : g_chk_addr
         $error("ADDR_W too narrow for NUM_SRC pages");
      end
   endgenerate

   pq_cmd_t            cmd;
   logic [NUM_SRC-1:0] sel_vec;
   logic [SRC_W-1:0]   src_idx;
   logic               load_hit;
   logic [1:0]         pq_vec [NUM_SRC];
   logic [NUM_SRC-1:0] evt_vec;
   logic               resp_valid_q;
   logic [63:0]        resp_data_q;

   irq_pq_decode #(
      .NUM_SRC      (NUM_SRC),
      .ADDR_W       (ADDR_W),
      .PAGE_BITS    (PAGE_BITS),
      .STORE_EOI_EN (STORE_EOI_EN)
   ) u_decode (
      .req_valid_i (req_valid_i),
      .req_write_i (req_write_i),
      .req_addr_i  (req_addr_i),
      .cmd_o       (cmd),
      .sel_o       (sel_vec),
      .src_o       (src_idx),
      .load_hit_o  (load_hit)
   );

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         irq_pq_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_i  (sel_vec[i]),
            .cmd_i  (cmd),
            .trig_i (trig_i[i]),
            .pq_o   (pq_vec[i]),
            .evt_o  (evt_vec[i])
         );
      end
   endgenerate

   irq_pq_notify_arb #(
      .NUM_SRC (NUM_SRC)
   ) u_notify (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_vec),
      .ready_i (notify_ready_i),
      .valid_o (notify_valid_o),
      .src_o   (notify_src_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid_q <= 1'b0;
         resp_data_q  <= '0;
      end else begin
         resp_valid_q <= req_valid_i && !req_write_i;
         if (req_valid_i && !req_write_i) begin
            resp_data_q <= load_hit ? {62'd0, pq_vec[src_idx]} : '1;
         end
      end
   end

   assign resp_valid_o = resp_valid_q;
   assign resp_data_o  = resp_data_q;

   AST_LOAD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !req_write_i) |=> resp_valid_o); // R11
   AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid_i || req_write_i) |=> !resp_valid_o); // R7
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_vec)); // R8

endmodule

// File: tb/irq_pq_bank_bench.sv
module irq_pq_bank_bench;

   localparam int NS = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] trig = '0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [15:0]   req_addr = '0;
   logic          resp_valid;
   logic [63:0]   resp_data;
   logic          notify_valid;
   logic [2:0]    notify_src;
   logic          notify_ready = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_tag = "R1";
   string exp_tag = "R1";

   int          m_st   [NS];
   bit          m_pend [NS];
   bit          e_rv = 0;
   logic [63:0] e_rd = '0;
   bit          e_nv = 0;
   int          e_src = 0;

   always #2ns clk = ~clk;

   irq_pq_bank u_irq_pq_bank (
      .clk            (clk),
      .rst_n          (rst_n),
      .trig_i         (trig),
      .req_valid_i    (req_valid),
      .req_write_i    (req_write),
      .req_addr_i     (req_addr),
      .resp_valid_o   (resp_valid),
      .resp_data_o    (resp_data),
      .notify_valid_o (notify_valid),
      .notify_src_o   (notify_src),
      .notify_ready_i (notify_ready)
   );

   function automatic int lowest_pend();
      for (int i = 0; i < NS; i++) if (m_pend[i]) return i;
      return 0;
   endfunction

   // Behavioural reference, advanced on each rising edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin m_st[i] = 0; m_pend[i] = 0; end
         e_rv = 0; e_nv = 0; e_src = 0;
      end else begin
         int page, off, op, val;
         bit ev [NS];
         page = int'(req_addr) / 4096;
         off  = int'(req_addr) % 4096;
         op = 0; val = 0;   // 0 none, 1 get, 2 eoi, 3 set
         if (req_valid && page < NS) begin
            if (!req_write) begin
               if (off == 'h000) op = 2;
               else if (off == 'h800) op = 1;
               else if (off == 'hC00 || off == 'hD00 || off == 'hE00 || off == 'hF00) begin
                  op = 3; val = (off - 'hC00) / 'h100;
               end
            end else if (off == 'h400) op = 2;
         end
         exp_tag = cur_tag;
         e_rv = req_valid && !req_write;
         if (e_rv) e_rd = (op != 0) ? 64'(m_st[page]) : '1;
         for (int s = 0; s < NS; s++) begin
            int v;
            v = m_st[s]; ev[s] = 0;
            if (op != 0 && s == page) begin
               if (op == 3) v = val;
               else if (op == 2) begin
                  if (v == 3) begin v = 2; ev[s] = 1; end
                  else if (v == 2) v = 0;
               end
            end
            if (trig[s]) begin
               if (v == 0) begin v = 2; ev[s] = 1; end
               else if (v == 2) v = 3;
            end
            m_st[s] = v;
         end
         if (e_nv && notify_ready) m_pend[lowest_pend()] = 0;
         for (int s = 0; s < NS; s++) if (ev[s]) m_pend[s] = 1;
         e_nv = 0;
         for (int s = 0; s < NS; s++) if (m_pend[s]) e_nv = 1;
         e_src = lowest_pend();
      end
   end

   // Comparison away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (resp_valid !== e_rv) begin
            errors++;
            $display("FAIL %s resp_valid actual=%0b expected=%0b", exp_tag, resp_valid, e_rv);
         end
         if (e_rv) begin
            checks++;
            if (resp_data !== e_rd) begin
               errors++;
               $display("FAIL %s resp_data actual=%h expected=%h", exp_tag, resp_data, e_rd);
            end
         end
         checks++;
         if (notify_valid !== e_nv) begin
            errors++;
            $display("FAIL %s notify_valid actual=%0b expected=%0b", exp_tag, notify_valid, e_nv);
         end
         if (e_nv) begin
            checks++;
            if (int'(notify_src) != e_src) begin
               errors++;
               $display("FAIL %s notify_src actual=%0d expected=%0d", exp_tag, notify_src, e_src);
            end
         end
      end
   end

   function automatic logic [15:0] adr(input int src, input int off);
      return 16'(src * 4096 + off);
   endfunction

   task automatic step(input logic [NS-1:0] t, input bit v, input bit w,
                       input logic [15:0] a, input bit rdy, input string tag);
      trig = t; req_valid = v; req_write = w; req_addr = a;
      notify_ready = rdy; cur_tag = tag;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input bit rdy, input string tag);
      for (int i = 0; i < n; i++) step('0, 0, 0, '0, rdy, tag);
   endtask

   task automatic load(input int src, input int off, input string tag);
      step('0, 1, 0, adr(src, off), 0, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;   // R1 reset state at the ports
      if (resp_valid !== 1'b0 || notify_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset resp_valid=%0b notify_valid=%0b expected 0 0", resp_valid, notify_valid);
      end
      rst_n = 1'b1;
      idle(2, 0, "R1");
      load(0, 'h800, "R2");                      // R2 read idle
      step(8'h01, 0, 0, '0, 0, "R4");            // R4 00 -> 10, notify
      step(8'h01, 0, 0, '0, 0, "R4");            // 10 -> 11
      step(8'h01, 0, 0, '0, 0, "R4");            // 11 stays
      load(0, 'h800, "R2");
      idle(2, 0, "R10");                         // R10 notify held
      idle(1, 1, "R10");                         // accept
      load(0, 'h000, "R6");                      // R6 11 -> 10 + notify
      load(0, 'h000, "R6");                      // 10 -> 00
      load(0, 'h000, "R6");                      // 00 unchanged
      idle(2, 1, "R6");
      load(2, 'hC00, "R3"); load(2, 'hD00, "R3");
      load(2, 'hE00, "R3"); load(2, 'hF00, "R3");
      load(2, 'h800, "R3"); load(2, 'hC00, "R3");
      load(3, 'hD00, "R5");                      // R5 mask
      step(8'h08, 0, 0, '0, 0, "R5");
      step(8'h08, 0, 0, '0, 0, "R5");
      load(3, 'h800, "R5");
      load(4, 'hF00, "R7");                      // R7 store EOI
      step('0, 1, 1, adr(4, 'h400), 0, "R7");
      load(4, 'h800, "R7");
      step('0, 1, 1, adr(4, 'h800), 0, "R7");    // ignored store
      step('0, 1, 1, adr(4, 'h000), 0, "R7");    // ignored store
      load(4, 'h800, "R7");
      idle(2, 1, "R7");
      load(9, 'h800, "R8");                      // R8 unmapped page
      load(12, 'hF00, "R8");
      load(5, 'h100, "R8");                      // unmapped offset
      load(5, 'h400, "R8");
      load(5, 'h800, "R8");
      load(1, 'hE00, "R9");                      // R9 collisions
      step(8'h02, 1, 0, adr(1, 'h000), 0, "R9"); // EOI 10->00 then trig ->10
      step(8'h02, 1, 0, adr(1, 'hC00), 0, "R9"); // force 00 then trig
      step(8'h02, 1, 0, adr(1, 'hD00), 0, "R9"); // force masked then trig
      load(1, 'h800, "R9");
      step(8'hF0, 0, 0, '0, 0, "R10");           // several sources at once
      step(8'h0C, 0, 0, '0, 1, "R10");
      idle(8, 1, "R10");
      for (int i = 0; i < 3000; i++) begin
         int src, sel;
         int offs [7] = '{'h000, 'h400, 'h800, 'hC00, 'hD00, 'hE00, 'hF00};
         src = $urandom_range(0, 9);
         sel = $urandom_range(0, 6);
         step(NS'($urandom & $urandom), ($urandom_range(0, 2) == 0),
              ($urandom_range(0, 3) == 0), adr(src, offs[sel]),
              ($urandom_range(0, 1) == 1), "R9");
      end
      idle(12, 1, "R11");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule